// File: doc/BRIEF.md
# Dual-Priority Interrupt Request Controller

This block keeps two sticky interrupt flags for a crate-bus module: a high-priority error flag and a low-priority data-ready flag. Each flag has its own enable bit. The serial receiver raises a flag with a one-cycle set pulse. After that the flag stays set until a bus command or a global strobe clears it. The block combines the enabled flags into one look-at-me request. The data-ready term can also be masked by a front-panel inhibit level, so routine responses do not interrupt the host at critical times.

Host access goes through a function code, a subaddress, the station select and a first-phase strobe. The decoder handles five kinds of command. It reads both flags as a two-bit status word, tests one flag through the Q response, and clears either flag alone or both flags together. It also enables or disables either flag's contribution to the request. Two global strobes reset the flags. The initialize strobe also restores the default enables (error on, data-ready off), while the clear strobe leaves the enables unchanged. Both global strobes, and the clear-all command, pulse a clear-buffers output for the neighbouring storage. An alarm level follows the error flag, so an external alarm can be driven whatever the enable setting.

Top module: `dual_prio_irq`

## Requirements
- R1: Reset (rst_n low) clears both flags, turns the error enable on and the data-ready enable off. It holds irq_req, q_resp, status_rd, alarm and clr_bufs at 0.
- R2: A set pulse (set_err or set_rdy) sets its flag on the next edge. The flag then stays set until it is cleared. If a set and a clear reach the same flag in the same cycle, the set wins.
- R3: Function 0 with subaddress 0 or 1 drives status_rd with bit 0 = error flag and bit 1 = data-ready flag. It also asserts q_resp. At all other times status_rd is 0.
- R4: Function 10 clears the error flag at subaddress 0 and the data-ready flag at subaddress 1 on the next edge. The other flag is not changed.
- R5: Function 9 with subaddress 0 clears both flags on the next edge, raises clr_bufs in the same cycle and asserts q_resp.
- R6: Function 26 sets an enable and function 24 clears it (subaddress 0 = error, 1 = data-ready) from the next edge on. The flags are not changed.
- R7: Function 27 with subaddress 0 or 1 asserts q_resp in that cycle exactly when the selected flag (0 = error, 1 = data-ready) is set.
- R8: irq_req = (error flag AND error enable) OR (data-ready flag AND data-ready enable AND NOT panel_inhibit).
- R9: init_stb raises clr_bufs in that cycle. On the next edge it clears both flags, sets the error enable and clears the data-ready enable.
- R10: clr_stb raises clr_bufs in that cycle and clears both flags on the next edge. The enables are not changed.
- R11: alarm equals the error flag, whatever the enables and panel_inhibit. It stays high until the error flag is cleared.
- R12: A command with stn_sel or strobe1 low is ignored. No state changes, and q_resp and status_rd stay 0.
- R13: q_resp is 0 for function codes other than 0, 9, 10, 24, 26 and 27. It is also 0 for subaddresses other than 0 and 1 (other than 0 for function 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stn_sel | input | 1 | Station select for this module |
| strobe1 | input | 1 | First-phase command strobe |
| fcode | input | 5 | Bus function code |
| subaddr | input | AW (4) | Bus subaddress |
| init_stb | input | 1 | Global initialize strobe |
| clr_stb | input | 1 | Global clear strobe |
| set_err | input | 1 | Set pulse for the error flag |
| set_rdy | input | 1 | Set pulse for the data-ready flag |
| panel_inhibit | input | 1 | Front-panel mask of the data-ready request |
| irq_req | output | 1 | Combined look-at-me request |
| status_rd | output | NFLAGS (2) | Flag status on a read command |
| q_resp | output | 1 | Q response for the current command |
| alarm | output | 1 | Error alarm level |
| clr_bufs | output | 1 | One-cycle clear-buffers request |

## Verification
The assertions assume that set pulses, global strobes and bus commands are held stable for one whole clock cycle and change only between edges. They also assume that the inhibit input is a clean level, and that the default parameters place the error flag at index 0 and gate only the data-ready flag. The stimulus drives every input one time unit after a rising edge and keeps it for exactly one cycle. Commands are framed with both the station select and the strobe, except on the cycles meant to show that a command is ignored. Set pulses are placed in the same cycle as clears to check the set-wins rule.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int FN_W = 5;

  localparam logic [FN_W-1:0] FN_READ    = 5'd0;
  localparam logic [FN_W-1:0] FN_CLR_ALL = 5'd9;
  localparam logic [FN_W-1:0] FN_CLR_ONE = 5'd10;
  localparam logic [FN_W-1:0] FN_DIS     = 5'd24;
  localparam logic [FN_W-1:0] FN_EN      = 5'd26;
  localparam logic [FN_W-1:0] FN_TEST    = 5'd27;

  // One flag's contribution to the request line.
  function automatic logic req_term(input logic flag, input logic en,
                                    input logic gated, input logic inhibit);
    return flag & en & ~(gated & inhibit);
  endfunction

  // Next value of a sticky flag: a set beats a same-cycle clear.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_pkg::*;
#(
  parameter int AW     = 4,
  parameter int NFLAGS = 2
) (
  input  logic              active_i,
  input  logic [FN_W-1:0]   fcode_i,
  input  logic [AW-1:0]     sub_i,
  output logic [NFLAGS-1:0] sel_clr_o,
  output logic [NFLAGS-1:0] sel_en_o,
  output logic [NFLAGS-1:0] sel_dis_o,
  output logic [NFLAGS-1:0] sel_test_o,
  output logic              read_o,
  output logic              clr_all_o,
  output logic              accept_o
);
  logic [NFLAGS-1:0] sub_hit;
  logic              sub_valid;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_sub
    assign sub_hit[i] = (sub_i == AW'(i));
  end

  assign sub_valid = |sub_hit;

  always_comb begin
    read_o     = active_i && (fcode_i == FN_READ) && sub_valid;
    clr_all_o  = active_i && (fcode_i == FN_CLR_ALL) && sub_hit[0];
    sel_clr_o  = (active_i && fcode_i == FN_CLR_ONE) ? sub_hit : '0;
    sel_en_o   = (active_i && fcode_i == FN_EN)      ? sub_hit : '0;
    sel_dis_o  = (active_i && fcode_i == FN_DIS)     ? sub_hit : '0;
    sel_test_o = (active_i && fcode_i == FN_TEST)    ? sub_hit : '0;
    accept_o   = read_o | clr_all_o | (|sel_clr_o) | (|sel_en_o) | (|sel_dis_o);
  end

  always_comb begin
    if (!active_i) begin
      AST_IDLE_NO_ACCEPT: assert (!accept_o && sel_test_o == '0); // R12
    end
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
  import irq_pkg::*;
#(
  parameter logic INIT_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic init_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic flag_o,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      en_o   <= INIT_EN;
    end else begin
      flag_o <= flag_next(flag_o, set_i, clr_i);
      if (init_i)        en_o <= INIT_EN;
      else if (en_set_i) en_o <= 1'b1;
      else if (en_clr_i) en_o <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o)); // R2
  AST_INIT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (en_o == INIT_EN)); // R9
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_pkg::*;
#(
  parameter int                NFLAGS    = 2,
  parameter logic [NFLAGS-1:0] GATE_MASK = 2'b10
) (
  input  logic [NFLAGS-1:0] flags_i,
  input  logic [NFLAGS-1:0] en_i,
  input  logic              inhibit_i,
  output logic              req_o
);
  logic [NFLAGS-1:0] term;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_term
    assign term[i] = req_term(flags_i[i], en_i[i], GATE_MASK[i], inhibit_i);
  end

  assign req_o = |term;
endmodule

// File: rtl/dual_prio_irq.sv
module dual_prio_irq
  import irq_pkg::*;
#(
  parameter int                AW        = 4,
  parameter int                NFLAGS    = 2,
  parameter int                ERR_IDX   = 0,
  parameter logic [NFLAGS-1:0] INIT_EN   = 2'b01,
  parameter logic [NFLAGS-1:0] GATE_MASK = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stn_sel,
  input  logic              strobe1,
  input  logic [FN_W-1:0]   fcode,
  input  logic [AW-1:0]     subaddr,
  input  logic              init_stb,
  input  logic              clr_stb,
  input  logic              set_err,
  input  logic              set_rdy,
  input  logic              panel_inhibit,
  output logic              irq_req,
  output logic [NFLAGS-1:0] status_rd,
  output logic              q_resp,
  output logic              alarm,
  output logic              clr_bufs
);
  logic              cmd_active;
  logic [NFLAGS-1:0] sel_clr, sel_en, sel_dis, sel_test;
  logic              cmd_read, cmd_clr_all, cmd_accept;
  logic [NFLAGS-1:0] flags, enables, set_vec, clr_vec;
  logic              global_clr;

  assign cmd_active = stn_sel & strobe1;
  assign global_clr = init_stb | clr_stb;

  irq_cmd_decode #(.AW(AW), .NFLAGS(NFLAGS)) u_dec (
    .active_i  (cmd_active),
    .fcode_i   (fcode),
    .sub_i     (subaddr),
    .sel_clr_o (sel_clr),
    .sel_en_o  (sel_en),
    .sel_dis_o (sel_dis),
    .sel_test_o(sel_test),
    .read_o    (cmd_read),
    .clr_all_o (cmd_clr_all),
    .accept_o  (cmd_accept)
  );

  always_comb begin
    set_vec = '0;
    set_vec[ERR_IDX] = set_err;
    set_vec[(ERR_IDX + 1) % NFLAGS] = set_rdy;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    assign clr_vec[i] = global_clr | cmd_clr_all | sel_clr[i];
    irq_flag_cell #(.INIT_EN(INIT_EN[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec[i]),
      .clr_i   (clr_vec[i]),
      .init_i  (init_stb),
      .en_set_i(sel_en[i]),
      .en_clr_i(sel_dis[i]),
      .flag_o  (flags[i]),
      .en_o    (enables[i])
    );
  end

  irq_combine #(.NFLAGS(NFLAGS), .GATE_MASK(GATE_MASK)) u_comb (
    .flags_i  (flags),
    .en_i     (enables),
    .inhibit_i(panel_inhibit),
    .req_o    (irq_req)
  );

  assign status_rd = cmd_read ? flags : '0;
  assign q_resp    = cmd_accept | (|(sel_test & flags));
  assign alarm     = flags[ERR_IDX];
  assign clr_bufs  = global_clr | cmd_clr_all;

  AST_Q_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_active |-> (!q_resp && status_rd == '0)); // R12
  AST_INHIBIT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_inhibit && !alarm) |-> !irq_req); // R8
  AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr_vec[ERR_IDX]) |=> alarm); // R11
  AST_INIT_CLRBUF: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |-> clr_bufs); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_err && !set_rdy) |=> (!alarm && !irq_req)); // R10
endmodule

// File: tb/dual_prio_irq_bench.sv
module dual_prio_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic       stn_sel = 0, strobe1 = 0, init_stb = 0, clr_stb = 0;
  logic       set_err = 0, set_rdy = 0, panel_inhibit = 0;
  logic [4:0] fcode = '0;
  logic [3:0] subaddr = '0;
  logic       irq_req, q_resp, alarm, clr_bufs;
  logic [1:0] status_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_prio_irq u_dual_prio_irq (
    .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .strobe1(strobe1),
    .fcode(fcode), .subaddr(subaddr), .init_stb(init_stb), .clr_stb(clr_stb),
    .set_err(set_err), .set_rdy(set_rdy), .panel_inhibit(panel_inhibit),
    .irq_req(irq_req), .status_rd(status_rd), .q_resp(q_resp),
    .alarm(alarm), .clr_bufs(clr_bufs)
  );

  typedef struct {
    logic [5:0] v;   // {irq, q, status[1:0], alarm, clr_bufs}
    string      tag;
  } exp_t;
  exp_t sbq[$];

  // Bench model: bit 0 = error, bit 1 = data-ready
  logic [1:0] m_flag = 2'b00;
  logic [1:0] m_en   = 2'b01;
  logic       m_inh  = 1'b0;

  task automatic step(input logic sel, input logic s1, input logic [4:0] f,
                      input logic [3:0] a, input logic ini, input logic clr,
                      input logic se, input logic sr, input string tag);
    logic ok, q, cb, irq, kill0, kill1;
    logic [1:0] st;
    exp_t e;
    @(posedge clk); #1;
    stn_sel = sel; strobe1 = s1; fcode = f; subaddr = a;
    init_stb = ini; clr_stb = clr; set_err = se; set_rdy = sr;
    panel_inhibit = m_inh;
    ok = sel & s1;
    q = 1'b0;
    if (ok) begin
      if (f == 5'd27 && a < 4'd2) q = m_flag[a[0]];
      else if ((f == 5'd0 || f == 5'd10 || f == 5'd24 || f == 5'd26) && a < 4'd2) q = 1'b1;
      else if (f == 5'd9 && a == 4'd0) q = 1'b1;
    end
    st  = (ok && f == 5'd0 && a < 4'd2) ? m_flag : 2'b00;
    cb  = ini | clr | (ok && f == 5'd9 && a == 4'd0);
    irq = (m_flag[0] & m_en[0]) | (m_flag[1] & m_en[1] & ~m_inh);
    e.v = {irq, q, st, m_flag[0], cb};
    e.tag = tag;
    sbq.push_back(e);
    kill0 = cb | (ok && f == 5'd10 && a == 4'd0);
    kill1 = cb | (ok && f == 5'd10 && a == 4'd1);
    m_flag[0] = se | (m_flag[0] & ~kill0);
    m_flag[1] = sr | (m_flag[1] & ~kill1);
    if (ini) m_en = 2'b01;
    else if (ok && a < 4'd2 && f == 5'd26) m_en[a[0]] = 1'b1;
    else if (ok && a < 4'd2 && f == 5'd24) m_en[a[0]] = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 5'd0, 4'd0, 0, 0, 0, 0, tag);
  endtask

  task automatic cmd(input logic [4:0] f, input logic [3:0] a, input string tag);
    step(1, 1, f, a, 0, 0, 0, 0, tag);
  endtask

  // Monitor: one scoreboard entry per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (rst_n && sbq.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = sbq.pop_front();
      act = {irq_req, q_resp, status_rd, alarm, clr_bufs};
      checks++;
      if (act !== e.v) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", e.tag, act, e.v);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({irq_req, q_resp, status_rd, alarm, clr_bufs} !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=%b",
               {irq_req, q_resp, status_rd, alarm, clr_bufs}, 6'b0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    idle("R1 after reset");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R2 set error");
    idle("R8 R11 error request and alarm");
    cmd(5'd0, 4'd0, "R3 read A0");
    cmd(5'd0, 4'd1, "R3 read A1");
    cmd(5'd0, 4'd2, "R13 read bad subaddr");
    cmd(5'd27, 4'd0, "R7 test error");
    cmd(5'd27, 4'd1, "R7 test ready clear");
    step(1, 0, 5'd10, 4'd0, 0, 0, 0, 0, "R12 no strobe1");
    step(0, 1, 5'd10, 4'd0, 0, 0, 0, 0, "R12 no station");
    idle("R12 error still set");
    cmd(5'd10, 4'd0, "R4 clear error");
    idle("R4 error gone");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R2 set ready");
    idle("R8 ready disabled at reset");
    cmd(5'd26, 4'd1, "R6 enable ready");
    idle("R6 R8 ready request");
    m_inh = 1'b1;
    idle("R8 inhibit masks ready");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R2 set error under inhibit");
    idle("R8 inhibit leaves error");
    m_inh = 1'b0;
    cmd(5'd27, 4'd1, "R7 test ready set");
    cmd(5'd10, 4'd1, "R4 clear ready only");
    cmd(5'd0, 4'd0, "R4 status after ready clear");
    cmd(5'd24, 4'd0, "R6 disable error");
    idle("R6 R11 alarm without enable");
    step(1, 1, 5'd10, 4'd0, 0, 0, 1, 0, "R2 set beats clear");
    idle("R2 error survives");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R2 set both");
    cmd(5'd9, 4'd0, "R5 clear all");
    idle("R5 both cleared");
    cmd(5'd9, 4'd1, "R13 clear all bad subaddr");
    cmd(5'd30, 4'd0, "R13 unknown function");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R2 set both again");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R10 clear strobe");
    idle("R10 flags cleared");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R10 set ready");
    idle("R10 ready enable kept");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R9 init strobe");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9 set ready");
    idle("R9 ready disabled");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9 set error");
    idle("R9 error enabled");
    cmd(5'd0, 4'd1, "R3 read both");
    idle("R3 idle read zero");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule